// File: doc/BRIEF.md
# Cascadable Pipelined Multiplier Slice

This block multiplies two signed 18-bit operands into a full-precision signed 36-bit product. Operand A always arrives on its own port. Operand B comes from one of two places, and an elaboration-time parameter picks which one. It is either the local B port, or a cascade input that the previous slice of a chain drives. The slice forwards the B value that actually reaches its multiplier on a cascade output. Several slices wired output-to-input can therefore share one B operand.

There are three optional pipeline stages: the A operand, the chosen B operand and the product. Each one is switched in by its own parameter. Each has its own clock enable and its own synchronous clear, and all of them run on one clock. An active-low asynchronous reset, released synchronously by the surrounding chip, clears every stage that is present. The latency from an operand to the product is the larger of the A and B stage counts, plus the product stage, so it is 0 to 2 cycles.

Top module: `mul_slice`

## Requirements
- R1: `prod` is the full signed two's-complement product of the A and B operands that reach the multiplier, with no truncation. For example, -131072 times -131072 gives 17179869184.
- R2: With `B_SRC` = `SRC_PORT`, the multiplier's B operand comes from `b_in` and `b_casc_in` has no effect. With `B_SRC` = `SRC_CHAIN`, it comes from `b_casc_in` and `b_in` has no effect.
- R3: `b_casc_out` always equals the multiplier's B operand. That is the B stage output when `REG_B` = 1, and otherwise the selected source in the same cycle.
- R4: All four combinations of `B_SRC` and `REG_B` work. A chain of slices joined through `b_casc_out` to `b_casc_in` delivers the head slice's B value to every slice, delayed by one cycle per registered B stage.
- R5: `REG_A` and `REG_P` each insert one register stage when set to 1 and none when set to 0. With all three stages at 0, `prod` follows its inputs in the same cycle.
- R6: When a stage is present and its clear (`clr_a`, `clr_b`, `clr_p`) is high at a clock edge, that stage becomes zero, whatever its clock enable is.
- R7: When a stage's clear is low and its enable (`ce_a`, `ce_b`, `ce_p`) is high, the stage loads its input. When both are low, it keeps its value.
- R8: While `rst_n` is low, every present stage reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for all stages |
| rst_n | input | 1 | Asynchronous active-low reset of all stages |
| a_in | input | 18 | Signed operand A |
| b_in | input | 18 | Signed operand B, local source |
| b_casc_in | input | 18 | Signed operand B, from the previous slice |
| ce_a | input | 1 | Enable of the A stage |
| ce_b | input | 1 | Enable of the B stage |
| ce_p | input | 1 | Enable of the product stage |
| clr_a | input | 1 | Synchronous clear of the A stage |
| clr_b | input | 1 | Synchronous clear of the B stage |
| clr_p | input | 1 | Synchronous clear of the product stage |
| prod | output | 36 | Signed product |
| b_casc_out | output | 18 | B operand seen by the multiplier, for the next slice |

## Verification
On every cycle, the assertions check each stage's behaviour. Clear must win over enable, a stage must load when enabled and must hold when idle. In the unregistered configurations they also check that the product matches the operands of the same cycle and that the cascade output follows the chosen source. Other behaviours need the bench's scenarios: the cycle-by-cycle delay of B down a chain of registered slices, full-range signed corner products, and the proof that the unselected B source has no effect. For these the bench runs two three-slice chains, one fully combinational and one fully registered, and compares them against a model.

// File: rtl/mul_slice_pkg.sv
package mul_slice_pkg;
  typedef enum logic {
    SRC_PORT  = 1'b0,
    SRC_CHAIN = 1'b1
  } b_src_e;
endpackage

// File: rtl/opt_stage.sv
module opt_stage #(
  parameter int W  = 18,
  parameter bit EN = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ce,
  input  logic         clr,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  generate
    if (EN) begin : g_reg
      logic [W-1:0] q_r;
      logic [W-1:0] q_nxt;

      always_comb begin
        q_nxt = q_r;
        if (clr) begin
          q_nxt = '0;
        end else if (ce) begin
          q_nxt = d;
        end
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          q_r <= '0;
        end else begin
          q_r <= q_nxt;
        end
      end

      assign q = q_r;

      // R6
      clr_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (q == '0));
      // R7
      load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ce && !clr) |=> (q == $past(d)));
      // R7
      hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce && !clr) |=> $stable(q));
    end else begin : g_wire
      logic unused_ctl;
      assign unused_ctl = ^{clk, rst_n, ce, clr};
      assign q = d;
    end
  endgenerate
endmodule

// File: rtl/mul_core.sv
module mul_core #(
  parameter int AW = 18,
  parameter int BW = 18,
  localparam int PW = AW + BW
) (
  input  logic [AW-1:0] op_a,
  input  logic [BW-1:0] op_b,
  output logic [PW-1:0] prod
);
  logic signed [PW-1:0] a_ext;
  logic signed [PW-1:0] b_ext;

  always_comb begin
    a_ext = PW'($signed(op_a));
    b_ext = PW'($signed(op_b));
    prod  = a_ext * b_ext;
  end
endmodule

// File: rtl/mul_slice.sv
module mul_slice
  import mul_slice_pkg::*;
#(
  parameter int     AW    = 18,
  parameter int     BW    = 18,
  parameter b_src_e B_SRC = SRC_PORT,
  parameter bit     REG_A = 1'b1,
  parameter bit     REG_B = 1'b1,
  parameter bit     REG_P = 1'b1,
  localparam int    PW    = AW + BW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] a_in,
  input  logic [BW-1:0] b_in,
  input  logic [BW-1:0] b_casc_in,
  input  logic          ce_a,
  input  logic          ce_b,
  input  logic          ce_p,
  input  logic          clr_a,
  input  logic          clr_b,
  input  logic          clr_p,
  output logic [PW-1:0] prod,
  output logic [BW-1:0] b_casc_out
);
  logic [BW-1:0] b_pick;
  logic [AW-1:0] a_op;
  logic [BW-1:0] b_op;
  logic [PW-1:0] raw_prod;

  assign b_pick = (B_SRC == SRC_CHAIN) ? b_casc_in : b_in;

  opt_stage #(.W(AW), .EN(REG_A)) u_a_stage (
    .clk(clk), .rst_n(rst_n), .ce(ce_a), .clr(clr_a), .d(a_in), .q(a_op)
  );

  opt_stage #(.W(BW), .EN(REG_B)) u_b_stage (
    .clk(clk), .rst_n(rst_n), .ce(ce_b), .clr(clr_b), .d(b_pick), .q(b_op)
  );

  mul_core #(.AW(AW), .BW(BW)) u_core (
    .op_a(a_op), .op_b(b_op), .prod(raw_prod)
  );

  opt_stage #(.W(PW), .EN(REG_P)) u_p_stage (
    .clk(clk), .rst_n(rst_n), .ce(ce_p), .clr(clr_p), .d(raw_prod), .q(prod)
  );

  assign b_casc_out = b_op;

  generate
    if (!REG_P) begin : g_comb_p
      // R1
      prod_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $signed(prod) == $signed(PW'($signed(a_op))) * $signed(PW'($signed(b_casc_out))));
    end
    if (!REG_A && !REG_P) begin : g_comb_a
      // R5
      a_through_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $signed(prod) == $signed(PW'($signed(a_in))) * $signed(PW'($signed(b_casc_out))));
    end
    if (!REG_B) begin : g_comb_b
      // R2
      b_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        b_casc_out == ((B_SRC == SRC_CHAIN) ? b_casc_in : b_in));
    end else begin : g_reg_b
      // R3
      b_tap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ce_b && !clr_b) |=> (b_casc_out == $past((B_SRC == SRC_CHAIN) ? b_casc_in : b_in)));
    end
    if (REG_P) begin : g_reg_p
      // R6
      p_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_p |=> (prod == '0));
    end
  endgenerate
endmodule

// File: tb/sim_mul_slice.sv
`timescale 1ns/1ps
module sim_mul_slice;
  import mul_slice_pkg::*;

  localparam int AW = 18;
  localparam int BW = 18;
  localparam int PW = 36;

  logic clk;
  logic rst_n;
  logic [AW-1:0] a [6];
  logic [BW-1:0] b_drv;
  logic [BW-1:0] junk;
  logic ce_a, ce_b, ce_p, clr_a, clr_b, clr_p;
  logic [PW-1:0] p [6];
  logic [BW-1:0] bc [6];

  int total;
  int bad;
  string tag_a;
  string tag_b;

  logic [AW-1:0] ma [3];
  logic [BW-1:0] mb [3];
  logic [PW-1:0] mp [3];

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // Chain A: all stages off, head uses local B, rest use cascade.
  mul_slice #(.B_SRC(SRC_PORT), .REG_A(1'b0), .REG_B(1'b0), .REG_P(1'b0)) u0 (
    .clk(clk), .rst_n(rst_n), .a_in(a[0]), .b_in(b_drv), .b_casc_in(junk),
    .ce_a(ce_a), .ce_b(ce_b), .ce_p(ce_p), .clr_a(clr_a), .clr_b(clr_b), .clr_p(clr_p),
    .prod(p[0]), .b_casc_out(bc[0]));
  mul_slice #(.B_SRC(SRC_CHAIN), .REG_A(1'b0), .REG_B(1'b0), .REG_P(1'b0)) u1 (
    .clk(clk), .rst_n(rst_n), .a_in(a[1]), .b_in(junk), .b_casc_in(bc[0]),
    .ce_a(ce_a), .ce_b(ce_b), .ce_p(ce_p), .clr_a(clr_a), .clr_b(clr_b), .clr_p(clr_p),
    .prod(p[1]), .b_casc_out(bc[1]));
  mul_slice #(.B_SRC(SRC_CHAIN), .REG_A(1'b0), .REG_B(1'b0), .REG_P(1'b0)) u2 (
    .clk(clk), .rst_n(rst_n), .a_in(a[2]), .b_in(~junk), .b_casc_in(bc[1]),
    .ce_a(ce_a), .ce_b(ce_b), .ce_p(ce_p), .clr_a(clr_a), .clr_b(clr_b), .clr_p(clr_p),
    .prod(p[2]), .b_casc_out(bc[2]));
  // Chain B: all stages on.
  mul_slice #(.B_SRC(SRC_PORT), .REG_A(1'b1), .REG_B(1'b1), .REG_P(1'b1)) u3 (
    .clk(clk), .rst_n(rst_n), .a_in(a[3]), .b_in(b_drv), .b_casc_in(junk),
    .ce_a(ce_a), .ce_b(ce_b), .ce_p(ce_p), .clr_a(clr_a), .clr_b(clr_b), .clr_p(clr_p),
    .prod(p[3]), .b_casc_out(bc[3]));
  mul_slice #(.B_SRC(SRC_CHAIN), .REG_A(1'b1), .REG_B(1'b1), .REG_P(1'b1)) u4 (
    .clk(clk), .rst_n(rst_n), .a_in(a[4]), .b_in(junk), .b_casc_in(bc[3]),
    .ce_a(ce_a), .ce_b(ce_b), .ce_p(ce_p), .clr_a(clr_a), .clr_b(clr_b), .clr_p(clr_p),
    .prod(p[4]), .b_casc_out(bc[4]));
  mul_slice #(.B_SRC(SRC_CHAIN), .REG_A(1'b1), .REG_B(1'b1), .REG_P(1'b1)) u5 (
    .clk(clk), .rst_n(rst_n), .a_in(a[5]), .b_in(~junk), .b_casc_in(bc[4]),
    .ce_a(ce_a), .ce_b(ce_b), .ce_p(ce_p), .clr_a(clr_a), .clr_b(clr_b), .clr_p(clr_p),
    .prod(p[5]), .b_casc_out(bc[5]));

  function automatic logic [PW-1:0] smul(input logic [AW-1:0] x, input logic [BW-1:0] y);
    longint xs, ys;
    xs = longint'($signed(x));
    ys = longint'($signed(y));
    return PW'(xs * ys);
  endfunction

  task automatic check(input string req, input string what, input logic [PW-1:0] act,
                       input logic [PW-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic model_update();
    logic [AW-1:0] na [3];
    logic [BW-1:0] nb [3];
    logic [PW-1:0] np [3];
    for (int k = 0; k < 3; k++) begin
      logic [BW-1:0] bsrc;
      bsrc = (k == 0) ? b_drv : mb[k-1];
      na[k] = clr_a ? '0 : (ce_a ? a[3+k] : ma[k]);
      nb[k] = clr_b ? '0 : (ce_b ? bsrc : mb[k]);
      np[k] = clr_p ? '0 : (ce_p ? smul(ma[k], mb[k]) : mp[k]);
    end
    for (int k = 0; k < 3; k++) begin
      ma[k] = rst_n ? na[k] : '0;
      mb[k] = rst_n ? nb[k] : '0;
      mp[k] = rst_n ? np[k] : '0;
    end
  endtask

  task automatic check_all();
    for (int k = 0; k < 3; k++) begin
      check(tag_a, $sformatf("comb prod slice %0d", k), p[k], smul(a[k], b_drv));
      check("R3", $sformatf("comb cascade out slice %0d", k), PW'(bc[k]), PW'(b_drv));
      check(tag_b, $sformatf("reg prod slice %0d", k), p[3+k], mp[k]);
      check("R4", $sformatf("reg cascade out slice %0d", k), PW'(bc[3+k]), PW'(mb[k]));
    end
  endtask

  task automatic step();
    @(posedge clk);
    model_update();
    @(negedge clk);
    #1;
    check_all();
  endtask

  task automatic rand_ops();
    for (int k = 0; k < 6; k++) a[k] = AW'($urandom);
    b_drv = BW'($urandom);
    junk  = BW'($urandom);
  endtask

  initial begin
    int cyc;
    cyc = 0;
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        bad++;
        total++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  initial begin
    logic [AW-1:0] ca [5];
    logic [BW-1:0] cb [5];
    void'($urandom(32'h5EED_0042));
    total = 0; bad = 0;
    tag_a = "R1"; tag_b = "R5";
    rst_n = 1'b0;
    ce_a = 0; ce_b = 0; ce_p = 0; clr_a = 0; clr_b = 0; clr_p = 0;
    for (int k = 0; k < 6; k++) a[k] = AW'(k + 3);
    b_drv = 18'd7; junk = 18'h2AAAA;
    for (int k = 0; k < 3; k++) begin ma[k] = '0; mb[k] = '0; mp[k] = '0; end
    repeat (3) @(posedge clk);
    @(negedge clk);
    #1;
    // R8: registered slices read zero during reset
    for (int k = 3; k < 6; k++) begin
      check("R8", "prod in reset", p[k], '0);
      check("R8", "cascade out in reset", PW'(bc[k]), '0);
    end
    rst_n = 1'b1;
    ce_a = 1; ce_b = 1; ce_p = 1;

    // R1 corner products, held for the pipelined chain to settle
    ca[0] = 18'h20000; cb[0] = 18'h20000;
    ca[1] = 18'h1FFFF; cb[1] = 18'h20000;
    ca[2] = 18'h1FFFF; cb[2] = 18'h1FFFF;
    ca[3] = 18'h00000; cb[3] = 18'h2A5A5;
    ca[4] = 18'h3FFFF; cb[4] = 18'h3FFFF;
    for (int i = 0; i < 5; i++) begin
      for (int k = 0; k < 6; k++) a[k] = ca[i];
      b_drv = cb[i];
      junk = BW'($urandom);
      repeat (5) step();
    end
    a[0] = 18'h20000; b_drv = 18'h20000;
    #1;
    check("R1", "min times min", p[0], 36'h400000000);

    // R2 / R4: random stimulus, unselected sources carry noise
    tag_a = "R2"; tag_b = "R4";
    for (int i = 0; i < 3000; i++) begin
      rand_ops();
      step();
    end

    // R6 / R7: random enables and clears
    tag_a = "R1"; tag_b = "R6";
    for (int i = 0; i < 3000; i++) begin
      rand_ops();
      ce_a = ($urandom % 4) != 0; ce_b = ($urandom % 4) != 0; ce_p = ($urandom % 4) != 0;
      clr_a = ($urandom % 8) == 0; clr_b = ($urandom % 8) == 0; clr_p = ($urandom % 8) == 0;
      step();
    end

    // R6 directed: clear together with enable
    ce_a = 1; ce_b = 1; ce_p = 1; clr_a = 1; clr_b = 1; clr_p = 1;
    rand_ops();
    step();
    for (int k = 3; k < 6; k++) begin
      check("R6", "prod cleared over enable", p[k], '0);
      check("R6", "cascade cleared over enable", PW'(bc[k]), '0);
    end

    // R7 directed: load, then hold with enables low
    clr_a = 0; clr_b = 0; clr_p = 0;
    tag_b = "R7";
    rand_ops();
    repeat (5) step();
    ce_a = 0; ce_b = 0; ce_p = 0;
    for (int i = 0; i < 6; i++) begin
      rand_ops();
      step();
    end
    for (int k = 3; k < 6; k++) begin
      check("R7", "prod held stays modelled", p[k], mp[k-3]);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule